// File: doc/BRIEF.md
# Power-State Transition Interrupt Controller

This block turns the encoded power state reported by a power sequencer, together with a power-on-reset event line, into interrupts for a host processor. It has three sticky event flags: one for a power-on-reset event, one for dropping into a low-power or off state, and one for arriving in the on state. Each flag has its own mask bit. Every flag that is pending and not masked drives one registered, active-high power-state interrupt line.

Software reaches the flags and masks through a small register port. A write has effect on the clock edge where `reg_wr_en` is high. Read data comes back on the cycle after the address is presented. Status bits are cleared by writing one to them. Two live indication outputs follow the present power state and can be routed to general-purpose pins.

The power state is encoded on two bits: OFF = 0, ON = 1, SLEEP = 2, BACKUP = 3. Every event is detected on the rising edge of its condition. A state that persists, or the power state seen in the first cycle after reset, raises no flag.

Top module: `pwr_state_irq`

## Requirements
- R1: The status register bit 0 (wake flag) sets on the clock edge at which the power state becomes ON (1) after being any other value.
- R2: The status register bit 1 (down flag) sets when the power state enters SLEEP (2) or OFF (0) from ON (1) or BACKUP (3). Moving between SLEEP and OFF does not set it.
- R3: The status register bit 2 (reset flag) sets on a rising edge of `por_evt`. Holding `por_evt` high sets it only once, so after it is cleared it stays clear.
- R4: A write to the status address (default 0) clears every status bit whose write-data bit is 1. It leaves every bit whose write-data bit is 0 unchanged.
- R5: The mask register (default address 1) uses the same bit positions (bit 0 wake, bit 1 down, bit 2 reset), where 1 masks the source. It resets to 3'b111, loads bits [2:0] of a write, and keeps its value when it is not written.
- R6: `irq_pwr` is high one cycle after any status bit is set while its mask bit is 0, and low one cycle after no such bit remains. Masked flags still set and stay readable.
- R7: When a rising edge of a source and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R8: `ind_on` is high exactly while `pwr_state` is ON (1). `ind_sleep` is high exactly while `pwr_state` is SLEEP (2). Both follow the input without a clock delay.
- R9: `reg_rdata` shows, one cycle after `reg_addr` is presented, the zero-extended status at the status address, the zero-extended mask at the mask address, and zero at any other address. Writes to other addresses change nothing.
- R10: After reset the status is 0 and `irq_pwr` is low, and the power state and `por_evt` levels present when reset ends raise no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_state | input | 2 | Current power state from the sequencer (OFF=0, ON=1, SLEEP=2, BACKUP=3) |
| por_evt | input | 1 | Power-on-reset event level; its rising edge is the event |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, one cycle after the address |
| irq_pwr | output | 1 | Primary power-state interrupt, registered, active high |
| ind_on | output | 1 | High while the power state is ON |
| ind_sleep | output | 1 | High while the power state is SLEEP |

## Verification
The assertions check on every cycle that a source edge always leaves its flag set even when a clear arrives in the same cycle, and that a write of one clears a flag that is not being set again. They also check that flags with no clear pending hold their value, that the mask changes only on a mask write, that the interrupt line follows the unmasked pending flags with one cycle of delay, and that a SLEEP-to-OFF move raises no down event. Only the bench scenarios can show that each flag sits at its stated bit position and that the reset values are right. The same holds for the once-only behaviour of a held level, the read mapping including unused addresses, the direct indication outputs, and a deferred unmask of a flag that was set while masked.

// File: rtl/pwr_irq_pkg.sv
package pwr_irq_pkg;

   typedef enum logic [1:0] {
      PS_OFF    = 2'd0,
      PS_ON     = 2'd1,
      PS_SLEEP  = 2'd2,
      PS_BACKUP = 2'd3
   } pwr_state_e;

   localparam int IRQ_N    = 3;
   localparam int BIT_WAKE = 0;
   localparam int BIT_DOWN = 1;
   localparam int BIT_POR  = 2;

endpackage

// File: rtl/pwr_evt_detect.sv
module pwr_evt_detect
   import pwr_irq_pkg::*;
#(
   parameter bit SYNC_POR = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       state_i,
   input  logic             por_i,
   output logic [IRQ_N-1:0] evt_o
);

   logic             por_s;
   logic [IRQ_N-1:0] cond;
   logic [IRQ_N-1:0] cond_q;

   generate
      if (SYNC_POR) begin : g_por_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= 2'b11;
            else        sync_q <= {sync_q[0], por_i};
         end
         assign por_s = sync_q[1];
      end else begin : g_por_direct
         assign por_s = por_i;
      end
   endgenerate

   always_comb begin
      cond           = '0;
      cond[BIT_WAKE] = (state_i == PS_ON);
      cond[BIT_DOWN] = (state_i == PS_SLEEP) || (state_i == PS_OFF);
      cond[BIT_POR]  = por_s;
   end

   // previous-condition registers reset high: levels seen at reset exit are not events
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= '1;
      else        cond_q <= cond;
   end

   generate
      for (genvar i = 0; i < IRQ_N; i++) begin : g_edge
         assign evt_o[i] = cond[i] & ~cond_q[i];
      end
   endgenerate

endmodule

// File: rtl/pwr_irq_regs.sv
module pwr_irq_regs
   import pwr_irq_pkg::*;
#(
   parameter logic [IRQ_N-1:0] MASK_RESET = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_N-1:0] set_i,
   input  logic             wr_status_i,
   input  logic             wr_mask_i,
   input  logic [IRQ_N-1:0] wbits_i,
   output logic [IRQ_N-1:0] status_o,
   output logic [IRQ_N-1:0] mask_o,
   output logic             irq_o
);

   logic [IRQ_N-1:0] status_q;
   logic [IRQ_N-1:0] mask_q;
   logic [IRQ_N-1:0] clr;
   logic [IRQ_N-1:0] status_d;
   logic             irq_q;

   assign clr      = wr_status_i ? wbits_i : '0;
   // a fresh event overrides a clear of the same bit
   assign status_d = (status_q & ~clr) | set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= MASK_RESET;
         irq_q    <= 1'b0;
      end else begin
         status_q <= status_d;
         if (wr_mask_i) mask_q <= wbits_i;
         irq_q    <= |(status_q & ~mask_q);
      end
   end

   assign status_o = status_q;
   assign mask_o   = mask_q;
   assign irq_o    = irq_q;

   generate
      for (genvar i = 0; i < IRQ_N; i++) begin : g_chk
         // R7
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> status_q[i]);
         // R4
         w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_status_i && wbits_i[i] && !set_i[i]) |=> !status_q[i]);
         // R4
         w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[i] && !(wr_status_i && wbits_i[i])) |=> status_q[i]);
      end
   endgenerate

   // R5
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mask_i |=> $stable(mask_q));
   // R6
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status_q & ~mask_q)) |=> irq_q);
   // R6
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status_q & ~mask_q)) |=> !irq_q);

endmodule

// File: rtl/pwr_state_irq.sv
module pwr_state_irq
   import pwr_irq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 16,
   parameter int STATUS_ADDR = 0,
   parameter int MASK_ADDR   = 1,
   parameter bit REG_RDATA   = 1'b1,
   parameter bit SYNC_POR    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        pwr_state,
   input  logic              por_evt,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_pwr,
   output logic              ind_on,
   output logic              ind_sleep
);

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(MASK_ADDR);

   generate
      if (DATA_W < IRQ_N) begin : g_bad_width
         $error("DATA_W must hold all interrupt flags");
      end
      if (STATUS_ADDR == MASK_ADDR) begin : g_bad_map
         $error("status and mask addresses must differ");
      end
      if (STATUS_ADDR >= (1 << ADDR_W) || MASK_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("register address does not fit ADDR_W");
      end
   endgenerate

   logic [IRQ_N-1:0]  evt;
   logic [IRQ_N-1:0]  status;
   logic [IRQ_N-1:0]  mask;
   logic              sel_status;
   logic              sel_mask;
   logic [DATA_W-1:0] rd_mux;

   assign sel_status = (reg_addr == A_STATUS);
   assign sel_mask   = (reg_addr == A_MASK);

   pwr_evt_detect #(
      .SYNC_POR (SYNC_POR)
   ) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (pwr_state),
      .por_i   (por_evt),
      .evt_o   (evt)
   );

   pwr_irq_regs #(
      .MASK_RESET ('1)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (evt),
      .wr_status_i (reg_wr_en && sel_status),
      .wr_mask_i   (reg_wr_en && sel_mask),
      .wbits_i     (reg_wdata[IRQ_N-1:0]),
      .status_o    (status),
      .mask_o      (mask),
      .irq_o       (irq_pwr)
   );

   always_comb begin
      rd_mux = '0;
      if (sel_status)    rd_mux = DATA_W'(status);
      else if (sel_mask) rd_mux = DATA_W'(mask);
   end

   generate
      if (REG_RDATA) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_mux;
         end
         assign reg_rdata = rdata_q;
      end else begin : g_rd_comb
         assign reg_rdata = rd_mux;
      end
   endgenerate

   assign ind_on    = (pwr_state == PS_ON);
   assign ind_sleep = (pwr_state == PS_SLEEP);

   // R2
   sleep_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == PS_OFF && $past(pwr_state) == PS_SLEEP) |-> !evt[BIT_DOWN]);

endmodule

// File: tb/pwr_state_irq_tb.sv
`timescale 1ns/1ps
module pwr_state_irq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  pwr_state = 2'd0;
   logic        por_evt = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq_pwr;
   logic        ind_on;
   logic        ind_sleep;

   int tests = 0;
   int fails = 0;

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } rd_item_t;
   rd_item_t sb_q[$];

   logic rd_req = 1'b0;
   logic rd_req_d = 1'b0;

   always #4 clk = ~clk;

   pwr_state_irq u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_state (pwr_state),
      .por_evt   (por_evt),
      .reg_wr_en (reg_wr_en),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_pwr   (irq_pwr),
      .ind_on    (ind_on),
      .ind_sleep (ind_sleep)
   );

   always @(posedge clk) rd_req_d <= rd_req;

   // monitor: compares read data against the scoreboard
   always @(negedge clk) begin
      if (rd_req_d) begin
         rd_item_t it;
         tests++;
         if (sb_q.size() == 0) begin
            fails++;
            $display("FAIL scoreboard empty: got %h", reg_rdata);
         end else begin
            it = sb_q.pop_front();
            if (reg_rdata !== it.exp) begin
               fails++;
               $display("FAIL %s: rdata=%h expected=%h", it.tag, reg_rdata, it.exp);
            end
         end
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
      rd_item_t it;
      @(negedge clk);
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
      reg_addr = a;
      rd_req   = 1'b1;
      @(negedge clk);
      rd_req   = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic go(input logic [1:0] s);
      @(negedge clk);
      pwr_state = s;
   endtask

   localparam logic [3:0] A_ST = 4'd0;
   localparam logic [3:0] A_MK = 4'd1;

   initial begin
      #(8 * 20000);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R10 reset state, OFF level at reset exit is no event
      chk("R10 irq after reset", irq_pwr, 1'b0);
      chk("R8 ind_on in OFF", ind_on, 1'b0);
      chk("R8 ind_sleep in OFF", ind_sleep, 1'b0);
      rd(A_ST, 16'h0000, "R10 status after reset");
      rd(A_MK, 16'h0007, "R5 mask reset value");

      // R1 wake event
      go(2'd1);
      #1 chk("R8 ind_on in ON", ind_on, 1'b1);
      rd(A_ST, 16'h0001, "R1 wake flag bit0");
      chk("R6 irq masked", irq_pwr, 1'b0);

      // R6 unmask all
      wr(A_MK, 16'h0000);
      tick(1);
      chk("R6 irq after unmask", irq_pwr, 1'b1);
      rd(A_MK, 16'h0000, "R5 mask written");

      // R4 write-zero keeps, write-one clears
      wr(A_ST, 16'h0000);
      rd(A_ST, 16'h0001, "R4 write zero keeps");
      wr(A_ST, 16'h0001);
      tick(1);
      chk("R6 irq drops", irq_pwr, 1'b0);
      rd(A_ST, 16'h0000, "R4 write one clears");

      // R2 down event into SLEEP, then SLEEP->OFF silent
      go(2'd2);
      #1 chk("R8 ind_sleep in SLEEP", ind_sleep, 1'b1);
      chk("R8 ind_on in SLEEP", ind_on, 1'b0);
      rd(A_ST, 16'h0002, "R2 down flag bit1");
      wr(A_ST, 16'h0002);
      go(2'd0);
      rd(A_ST, 16'h0000, "R2 sleep to off no event");
      go(2'd3);
      go(2'd0);
      rd(A_ST, 16'h0002, "R2 backup to off sets");
      wr(A_ST, 16'h0007);

      // R3 reset event once per rising edge
      @(negedge clk) por_evt = 1'b1;
      rd(A_ST, 16'h0004, "R3 reset flag bit2");
      wr(A_ST, 16'h0004);
      tick(3);
      rd(A_ST, 16'h0000, "R3 held level sets once");
      @(negedge clk) por_evt = 1'b0;

      // R7 set wins over clear
      go(2'd1);
      go(2'd3);
      @(negedge clk);
      pwr_state = 2'd1;
      reg_addr  = A_ST;
      reg_wdata = 16'h0001;
      reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
      rd(A_ST, 16'h0001, "R7 set wins");

      // R6 masked flag sets, deferred unmask
      wr(A_MK, 16'h0007);
      wr(A_ST, 16'h0007);
      go(2'd3);
      go(2'd2);
      tick(2);
      chk("R6 irq stays low masked", irq_pwr, 1'b0);
      rd(A_ST, 16'h0002, "R6 masked flag readable");
      wr(A_MK, 16'h0005);
      tick(1);
      chk("R6 irq on deferred unmask", irq_pwr, 1'b1);

      // R9 unused address
      wr(4'd5, 16'h0007);
      rd(4'd5, 16'h0000, "R9 unused address reads zero");
      rd(A_MK, 16'h0005, "R9 mask unchanged by stray write");
      rd(A_ST, 16'h0002, "R9 status unchanged by stray write");

      tick(3);
      tests++;
      if (sb_q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard left %0d items, expected 0", sb_q.size());
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule